// File: doc/BRIEF.md
# Fuse Array Read Sequencer

This block reads a run of consecutive bytes out of a one-time-programmable fuse array macro. A host asks for a read by pulsing `start` with a starting byte address and a byte count. The sequencer then drives the macro's packed control word through a fixed series of phases: select, open, address, strobe and close. Microsecond guard times separate the phases. It captures one byte at the end of each strobe pulse and hands each byte out on a valid/ready byte stream, in ascending address order.

Guard times are whole microseconds. They are counted from a tick that is divided down from the system clock, and the divider ratio is the parameter `CLK_MHZ`. The divider restarts at the start of every phase, so each phase lasts at least its nominal time. Programming, power-down and power-select controls of the macro stay inactive; the block only reads.

Output stream rules: `rd_valid` rises once per byte and stays high, with `rd_data` unchanged, until a cycle in which `rd_ready` is high. While the stream is stalled the sequencer waits with the strobe already low and does not move on to the next address. With `rd_ready` tied high, each byte appears as a single-cycle valid pulse.

Top module: `fuse_read_seq`

## Requirements
- R1: Control word layout is: bit 0 select (active low), bit 1 strobe, bit 2 load, bit 3 program-enable (active low), bits 13:6 the byte address. All other bits are zero. After reset and whenever idle, the word is 14'h009, `busy`, `done` and `rd_valid` are low.
- R2: On the clock after an accepted start with a non-zero count, the word is exactly 14'h001 for one cycle. It then becomes 14'h00C (load and program-enable high, select low), which is held for at least STEP_US before the first address is applied.
- R3: While select is low (bit 0 = 0), program-enable (bit 3) is high.
- R4: For every byte, the address field is cleared and then loaded with the current address. It is held for at least STEP_US before the strobe rises and is unchanged when the strobe rises. The strobe stays high for at least STEP_US, and the byte is sampled from `fuse_dout` at the end of that high time.
- R5: Between the strobe falling and the next strobe rising, at least STEP_US passes.
- R6: Exactly `byte_cnt` bytes are delivered, for addresses start, start+1, … modulo 256, in that order, each equal to the macro's data at that address.
- R7: While `rd_valid` is high and `rd_ready` is low, `rd_valid` stays high and `rd_data` is stable on the next clock.
- R8: After the last strobe falls, at least two STEP_US periods pass before select rises. At least CLOSE_US then passes before `done`.
- R9: A start with `byte_cnt` = 0 gives `done` on the next clock and leaves the control word at 14'h009 throughout.
- R10: `busy` is high from the clock after an accepted start through the `done` cycle. `done` is a one-cycle pulse, once per request. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Read request strobe, taken only when idle |
| start_addr | input | 8 | First byte address |
| byte_cnt | input | CNT_W | Number of bytes to read (0 allowed) |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| fuse_ctrl | output | 14 | Packed control word to the fuse macro |
| fuse_dout | input | 8 | Data byte from the fuse macro |
| rd_valid | output | 1 | Output byte valid |
| rd_ready | input | 1 | Consumer ready for the output byte |
| rd_data | output | 8 | Output byte |

## Verification
On every cycle, assertions check the select/program-enable pairing, the address being steady at the strobe rise, the output byte being held under back-pressure, the single-cycle `done` pulse, and the immediate finish of zero-length requests. The guard-time minimums, the exact opening words, the byte values and their order across address wrap, and the refusal of a second start can only be shown by the bench's scenarios. The bench sweeps start addresses near both ends of the 8-bit space against several counts, with and without stalls, and checks them against a modelled macro.

// File: rtl/fuse_seq_pkg.sv
package fuse_seq_pkg;
  localparam int CTRL_W   = 14;
  localparam int ADDR_W   = 8;
  localparam int SEL_BIT  = 0;
  localparam int STB_BIT  = 1;
  localparam int LOAD_BIT = 2;
  localparam int PGM_BIT  = 3;
  localparam int ADDR_LSB = 6;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SEL, ST_OPEN, ST_ACLR, ST_ASET, ST_STRB,
    ST_OUT, ST_GAP, ST_TAIL, ST_CLOSE, ST_DONE
  } seq_st_e;

  function automatic logic [CTRL_W-1:0] pack_ctrl(
    input logic sel_n, input logic stb, input logic load,
    input logic pgm_n, input logic [ADDR_W-1:0] addr);
    logic [CTRL_W-1:0] w;
    w = '0;
    w[SEL_BIT]  = sel_n;
    w[STB_BIT]  = stb;
    w[LOAD_BIT] = load;
    w[PGM_BIT]  = pgm_n;
    w[ADDR_LSB +: ADDR_W] = addr;
    return w;
  endfunction
endpackage

// File: rtl/us_tick_gen.sv
module us_tick_gen #(
  parameter int CLK_MHZ = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int DIV_W = (CLK_MHZ > 1) ? $clog2(CLK_MHZ) : 1;

  logic [DIV_W-1:0] div_q;

  assign tick = !clr && (div_q == DIV_W'(CLK_MHZ - 1));

  always_ff @(posedge clk) begin
    if (rst || clr || tick) div_q <= '0;
    else                    div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/guard_timer.sv
module guard_timer #(
  parameter int TW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          tick,
  input  logic [TW-1:0] target,
  output logic          expired
);
  logic [TW-1:0] cnt_q;

  assign expired = !clr && (cnt_q == target);

  always_ff @(posedge clk) begin
    if (rst || clr)                  cnt_q <= '0;
    else if (tick && cnt_q != target) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/fuse_read_seq.sv
module fuse_read_seq
  import fuse_seq_pkg::*;
#(
  parameter int CLK_MHZ  = 200,
  parameter int STEP_US  = 2,
  parameter int CLOSE_US = 1,
  parameter int CNT_W    = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [7:0]       start_addr,
  input  logic [CNT_W-1:0] byte_cnt,
  output logic             busy,
  output logic             done,
  output logic [13:0]      fuse_ctrl,
  input  logic [7:0]       fuse_dout,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data
);
  localparam int MAX_US = (STEP_US > CLOSE_US) ? STEP_US : CLOSE_US;
  localparam int TW     = $clog2(MAX_US + 1);

  seq_st_e state, nxt;
  logic [ADDR_W-1:0] cur_addr;
  logic [CNT_W-1:0]  left_q;
  logic [7:0]        data_q;
  logic [CTRL_W-1:0] ctrl_q, ctrl_n;
  logic              tmr_clr, tick, expired;
  logic [TW-1:0]     target;

  us_tick_gen #(.CLK_MHZ(CLK_MHZ)) u_tick (
    .clk(clk), .rst(rst), .clr(tmr_clr), .tick(tick));

  guard_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst(rst), .clr(tmr_clr), .tick(tick),
    .target(target), .expired(expired));

  always_comb begin
    case (state)
      ST_OPEN, ST_ASET, ST_STRB, ST_GAP, ST_TAIL: target = TW'(STEP_US);
      ST_CLOSE:                                   target = TW'(CLOSE_US);
      default:                                    target = '0;
    endcase
  end

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:  if (start) nxt = (byte_cnt == '0) ? ST_DONE : ST_SEL;
      ST_SEL:   nxt = ST_OPEN;
      ST_OPEN:  if (expired) nxt = ST_ACLR;
      ST_ACLR:  nxt = ST_ASET;
      ST_ASET:  if (expired) nxt = ST_STRB;
      ST_STRB:  if (expired) nxt = ST_OUT;
      ST_OUT:   if (rd_ready) nxt = ST_GAP;
      ST_GAP:   if (expired) nxt = (left_q == CNT_W'(1)) ? ST_TAIL : ST_ACLR;
      ST_TAIL:  if (expired) nxt = ST_CLOSE;
      ST_CLOSE: if (expired) nxt = ST_DONE;
      ST_DONE:  nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  // control word for the state being entered
  always_comb begin
    case (nxt)
      ST_SEL:            ctrl_n = pack_ctrl(1'b1, 1'b0, 1'b0, 1'b0, '0);
      ST_OPEN, ST_ACLR,
      ST_TAIL:           ctrl_n = pack_ctrl(1'b0, 1'b0, 1'b1, 1'b1, '0);
      ST_ASET, ST_OUT,
      ST_GAP:            ctrl_n = pack_ctrl(1'b0, 1'b0, 1'b1, 1'b1, cur_addr);
      ST_STRB:           ctrl_n = pack_ctrl(1'b0, 1'b1, 1'b1, 1'b1, cur_addr);
      ST_CLOSE:          ctrl_n = pack_ctrl(1'b1, 1'b0, 1'b1, 1'b1, '0);
      default:           ctrl_n = pack_ctrl(1'b1, 1'b0, 1'b0, 1'b1, '0);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      ctrl_q   <= pack_ctrl(1'b1, 1'b0, 1'b0, 1'b1, '0);
      tmr_clr  <= 1'b1;
      cur_addr <= '0;
      left_q   <= '0;
      data_q   <= '0;
    end else begin
      state   <= nxt;
      ctrl_q  <= ctrl_n;
      tmr_clr <= (nxt != state);
      if (state == ST_IDLE && start) begin
        cur_addr <= start_addr;
        left_q   <= byte_cnt;
      end
      if (state == ST_STRB && expired) data_q <= fuse_dout;
      if (state == ST_GAP && expired) begin
        cur_addr <= cur_addr + 1'b1;
        left_q   <= left_q - 1'b1;
      end
    end
  end

  assign fuse_ctrl = ctrl_q;
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_DONE);
  assign rd_valid  = (state == ST_OUT);
  assign rd_data   = data_q;

  // R3
  pgm_off_chk: assert property (@(posedge clk) disable iff (rst)
    !fuse_ctrl[SEL_BIT] |-> fuse_ctrl[PGM_BIT]);
  // R4
  addr_steady_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fuse_ctrl[STB_BIT]) |-> $stable(fuse_ctrl[ADDR_LSB +: ADDR_W]));
  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done && !busy);
  // R9
  zero_len_chk: assert property (@(posedge clk) disable iff (rst)
    !busy && start && byte_cnt == '0 |=> done && $stable(fuse_ctrl));
endmodule

// File: tb/tb_fuse_read_seq.sv
module tb_fuse_read_seq;
  localparam int MHZ = 3;
  localparam int STEP_CYC = 2 * MHZ;
  localparam int CLOSE_CYC = 1 * MHZ;

  logic clk = 0, rst = 1, start = 0, rd_ready = 1;
  logic [7:0] start_addr = 0;
  logic [8:0] byte_cnt = 0;
  logic busy, done, rd_valid;
  logic [13:0] fuse_ctrl;
  logic [7:0] fuse_dout, rd_data;

  int total = 0, bad = 0, cyc = 0;
  int n_got = 0, n_done = 0;
  logic [7:0] got [0:299];
  bit stall = 0, have_fall = 0, pv = 0, pr = 1;
  logic [7:0] pd = 0;
  logic [13:0] pw = 14'h009;
  int t_addr = 0, t_rise = 0, t_fall = 0, t_csn = -1;

  always #2.5 clk = ~clk;

  fuse_read_seq #(.CLK_MHZ(MHZ), .STEP_US(2), .CLOSE_US(1), .CNT_W(9)) dut (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .byte_cnt(byte_cnt), .busy(busy), .done(done), .fuse_ctrl(fuse_ctrl),
    .fuse_dout(fuse_dout), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data));

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11)) ^ 8'h5C;
  endfunction

  // fuse macro model: data only while selected, loaded and strobed
  assign fuse_dout = (fuse_ctrl[1] && !fuse_ctrl[0] && fuse_ctrl[2])
                     ? pat(int'(fuse_ctrl[13:6])) : 8'h00;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (fuse_ctrl != pw) begin
        if (fuse_ctrl[13:6] != pw[13:6]) t_addr = cyc;
        check(fuse_ctrl[0] || fuse_ctrl[3], "R3", fuse_ctrl, 14'h00C);
        if (fuse_ctrl[1] && !pw[1]) begin
          check(cyc - t_addr >= STEP_CYC, "R4 addr setup", cyc - t_addr, STEP_CYC);
          if (have_fall) check(cyc - t_fall >= STEP_CYC, "R5", cyc - t_fall, STEP_CYC);
          t_rise = cyc;
        end
        if (!fuse_ctrl[1] && pw[1]) begin
          check(cyc - t_rise >= STEP_CYC, "R4 strobe width", cyc - t_rise, STEP_CYC);
          t_fall = cyc; have_fall = 1;
        end
        if (fuse_ctrl[0] && !pw[0] && fuse_ctrl[2]) begin
          check(cyc - t_fall >= 2 * STEP_CYC, "R8 tail", cyc - t_fall, 2 * STEP_CYC);
          t_csn = cyc; have_fall = 0;
        end
        pw = fuse_ctrl;
      end
      if (done) begin
        n_done++;
        if (t_csn >= 0) begin
          check(cyc - t_csn >= CLOSE_CYC, "R8 close", cyc - t_csn, CLOSE_CYC);
          t_csn = -1;
        end
      end
      if (pv && !pr) check(rd_valid && rd_data == pd, "R7", rd_data, pd);
      rd_ready = stall ? ((cyc % 4) == 0) : 1'b1;
      if (rd_valid && rd_ready && n_got < 300) begin
        got[n_got] = rd_data;
        n_got++;
      end
      pv = rd_valid; pr = rd_ready; pd = rd_data;
    end
  end

  task automatic run(input int a, input int n, input bit stl, input bit poke);
    stall = stl; n_got = 0; n_done = 0;
    @(negedge clk); start = 1; start_addr = 8'(a); byte_cnt = 9'(n);
    @(negedge clk); start = 0;
    if (n == 0) begin
      check(done == 1'b1, "R9 done", done, 1);
      check(fuse_ctrl == 14'h009, "R9 pins", fuse_ctrl, 14'h009);
    end else begin
      check(fuse_ctrl == 14'h001, "R2 select word", fuse_ctrl, 14'h001);
      check(busy == 1'b1, "R10 busy", busy, 1);
      @(negedge clk);
      check(fuse_ctrl == 14'h00C, "R2 open word", fuse_ctrl, 14'h00C);
    end
    if (poke) begin
      repeat (20) @(negedge clk);
      start = 1; start_addr = 8'(a) ^ 8'h55; byte_cnt = 9'd7;
      @(negedge clk); start = 0;
    end
    while (busy) @(negedge clk);
    check(n_done == 1, "R10 done count", n_done, 1);
    check(n_got == n, "R6 byte count", n_got, n);
    for (int i = 0; i < n && i < 300; i++)
      check(got[i] == pat((a + i) & 255), "R6 byte", got[i], pat((a + i) & 255));
    check(fuse_ctrl == 14'h009 && !rd_valid, "R1 idle", fuse_ctrl, 14'h009);
  endtask

  initial begin
    int addrs [5] = '{0, 1, 127, 254, 255};
    repeat (3) @(negedge clk);
    check(fuse_ctrl == 14'h009, "R1 reset word", fuse_ctrl, 14'h009);
    check(!busy && !done && !rd_valid, "R1 reset flags", {busy, done, rd_valid}, 0);
    rst = 0;
    @(negedge clk);
    run(5, 0, 0, 0);
    foreach (addrs[k])
      for (int n = 1; n <= 4; n++) run(addrs[k], n, 0, 0);
    run(250, 9, 1, 0);
    run(3, 4, 0, 1);
    run(255, 0, 0, 0);
    run(128, 256, 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule